// File: doc/BRIEF.md
# Eight-Pin GPIO Port with Shared Pull-up and Edge-Select Control

This block is one 8-pin general-purpose I/O port hanging off a small microcontroller I/O bus. Software writes a per-pin data register and a write-only pull-up register. For every pin the pair of bits is turned into three pad controls: a current-sink enable that pulls the pin low, a pull-up resistor enable, and a high-impedance indication. The pull-up register bits are active low, and the same bit also picks which pin transition raises that pin's interrupt. The pad's analog parts (sink DAC, resistor, Schmitt trigger) are outside the block; they appear here only as control outputs and a digital pin level input.

Reading the data register address returns the pin level after a two-flop synchronizer, not the value that was written. Each pin owns a sticky pending bit set by the selected edge of its synchronized level. Pending bits are cleared by writing ones, and are gated by an enable mask into a single interrupt line. A suspend input forces every sink enable off while it is high. The bus read path is combinational from registered state; writes take effect on the clock edge that samples the write strobe.

Top module: `gpio_pullup_port`

## Requirements
- R1: A pin whose data bit is 0 has sink_en=1, pullup_en=0 and hiz=0, whatever its pull-up bit holds (suspend low).
- R2: A pin with data bit 1 and pull-up bit 0 has pullup_en=1, sink_en=0 and hiz=0.
- R3: A pin with data bit 1 and pull-up bit 1 has hiz=1, sink_en=0 and pullup_en=0.
- R4: While suspend is high every sink_en bit is 0; pullup_en and hiz are unaffected, and sink drive returns when suspend falls.
- R5: After reset the data register is 0xFF, the pull-up register 0x00, the enable mask and pending bits 0x00; so pullup_en=0xFF, sink_en=0x00, hiz=0x00, irq=0, and the synchronized pin level starts at all ones.
- R6: The pull-up register is written at address 0x08 and is write-only: a read of 0x08 returns 0x00, and a write there changes hiz/pullup_en from the next clock edge.
- R7: A read of the data address 0x00 returns the synchronized pin level, not the written data, and a pin change is visible there after two rising clock edges.
- R8: With a pull-up bit of 0, a high-to-low transition of the synchronized pin sets that pin's pending bit; a low-to-high transition does not.
- R9: With a pull-up bit of 1, a low-to-high transition sets that pin's pending bit; a high-to-low transition does not.
- R10: Pending bits (read at 0x24) stay set until a write to 0x24 with a 1 in that bit position; bits written 0 are kept, and an edge arriving in the same cycle as the clear leaves the bit set.
- R11: irq is 1 exactly when some pin has both its pending bit and its enable bit (register at 0x20, readable) set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | 8 | I/O bus address |
| bus_wr | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current address (0 for unmapped or write-only) |
| pin_in | input | 8 | Digital pin level from the input threshold stage |
| suspend | input | 1 | Forces all sink drive off while high |
| sink_en | output | 8 | Per-pin current-sink (drive low) enable |
| pullup_en | output | 8 | Per-pin pull-up resistor enable |
| hiz | output | 8 | Per-pin high-impedance indication |
| irq | output | 1 | OR of enabled pending bits |

## Verification
The hardest case to reach from the ports is a pending bit being set and cleared on the same clock edge. The edge event only exists during the one cycle in which the second synchronizer stage holds the new level and the previous-level flop still holds the old one. The bench changes a pin on a falling clock edge, counts two more falling edges so that it knows that cycle has arrived, and drives the write-one-to-clear strobe exactly then. It then reads the pending register to confirm that the set took priority.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  localparam int unsigned PIN_W  = 8;
  localparam int unsigned ADDR_W = 8;

  localparam logic [ADDR_W-1:0] ADR_DATA = 8'h00;
  localparam logic [ADDR_W-1:0] ADR_PULL = 8'h08;
  localparam logic [ADDR_W-1:0] ADR_IEN  = 8'h20;
  localparam logic [ADDR_W-1:0] ADR_PEND = 8'h24;

  typedef struct packed {
    logic sink;
    logic pull;
    logic float;
  } pad_ctl_t;
endpackage

// File: rtl/gpio_rst_sync.sv
module gpio_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 2'b00;
    end else begin
      stage_q <= stage_d;
    end
  end

  assign rst_ok = stage_q[1];
endmodule

// File: rtl/gpio_pin_sync.sv
module gpio_pin_sync #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_ok,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] lvl,
  output logic [W-1:0] lvl_prev
);
  logic [W-1:0] meta_q, lvl_q, prev_q;
  logic [W-1:0] meta_d, lvl_d, prev_d;

  always_comb begin
    meta_d = pin_in;
    lvl_d  = meta_q;
    prev_d = lvl_q;
  end

  // Reset to all ones: pins are pulled high out of reset.
  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      meta_q <= '1;
      lvl_q  <= '1;
      prev_q <= '1;
    end else begin
      meta_q <= meta_d;
      lvl_q  <= lvl_d;
      prev_q <= prev_d;
    end
  end

  assign lvl      = lvl_q;
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_drive_decode.sv
module gpio_drive_decode
  import gpio_port_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] data_bits,
  input  logic [W-1:0] pull_bits,
  input  logic         suspend,
  output logic [W-1:0] sink_en,
  output logic [W-1:0] pullup_en,
  output logic [W-1:0] hiz
);
  for (genvar i = 0; i < W; i++) begin : g_pin
    pad_ctl_t ctl;
    always_comb begin
      ctl.sink  = ~data_bits[i] & ~suspend;
      ctl.pull  =  data_bits[i] & ~pull_bits[i];
      ctl.float =  data_bits[i] &  pull_bits[i];
    end
    assign sink_en[i]   = ctl.sink;
    assign pullup_en[i] = ctl.pull;
    assign hiz[i]       = ctl.float;
  end
endmodule

// File: rtl/gpio_pullup_port.sv
module gpio_pullup_port
  import gpio_port_pkg::*;
#(
  parameter int unsigned          W         = PIN_W,
  parameter int unsigned          AW        = ADDR_W,
  parameter logic [ADDR_W-1:0]    DATA_ADDR = ADR_DATA,
  parameter logic [ADDR_W-1:0]    PULL_ADDR = ADR_PULL,
  parameter logic [ADDR_W-1:0]    IEN_ADDR  = ADR_IEN,
  parameter logic [ADDR_W-1:0]    PEND_ADDR = ADR_PEND
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_in,
  input  logic          suspend,
  output logic [W-1:0]  sink_en,
  output logic [W-1:0]  pullup_en,
  output logic [W-1:0]  hiz,
  output logic          irq
);
  logic rst_ok;
  logic [W-1:0] data_q, pull_q, ien_q, pend_q;
  logic [W-1:0] data_d, pull_d, ien_d, pend_d;
  logic         data_we, pull_we, ien_we, pend_we;
  logic [W-1:0] lvl, lvl_prev, edge_evt;

  gpio_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  gpio_pin_sync #(.W(W)) u_sync (
    .clk      (clk),
    .rst_ok   (rst_ok),
    .pin_in   (pin_in),
    .lvl      (lvl),
    .lvl_prev (lvl_prev)
  );

  gpio_drive_decode #(.W(W)) u_drv (
    .data_bits (data_q),
    .pull_bits (pull_q),
    .suspend   (suspend),
    .sink_en   (sink_en),
    .pullup_en (pullup_en),
    .hiz       (hiz)
  );

  // Pull bit 1 selects rising edges, 0 selects falling edges.
  always_comb begin
    edge_evt = (pull_q & lvl & ~lvl_prev) | (~pull_q & ~lvl & lvl_prev);
  end

  always_comb begin
    data_we = bus_wr && (bus_addr == DATA_ADDR[AW-1:0]);
    pull_we = bus_wr && (bus_addr == PULL_ADDR[AW-1:0]);
    ien_we  = bus_wr && (bus_addr == IEN_ADDR[AW-1:0]);
    pend_we = bus_wr && (bus_addr == PEND_ADDR[AW-1:0]);

    data_d = data_we ? bus_wdata : data_q;
    pull_d = pull_we ? bus_wdata : pull_q;
    ien_d  = ien_we  ? bus_wdata : ien_q;
    // A new edge takes priority over a simultaneous clear.
    pend_d = (pend_q & ~(pend_we ? bus_wdata : '0)) | edge_evt;
  end

  always_ff @(posedge clk or negedge rst_ok) begin
    if (!rst_ok) begin
      data_q <= '1;
      pull_q <= '0;
      ien_q  <= '0;
      pend_q <= '0;
    end else begin
      data_q <= data_d;
      pull_q <= pull_d;
      ien_q  <= ien_d;
      pend_q <= pend_d;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_addr == DATA_ADDR[AW-1:0]) begin
      bus_rdata = lvl;
    end else if (bus_addr == IEN_ADDR[AW-1:0]) begin
      bus_rdata = ien_q;
    end else if (bus_addr == PEND_ADDR[AW-1:0]) begin
      bus_rdata = pend_q;
    end
  end

  assign irq = |(pend_q & ien_q);
endmodule

// File: rtl/gpio_pullup_port_chk.sv
module gpio_pullup_port_chk #(
  parameter int unsigned W         = 8,
  parameter int unsigned AW        = 8,
  parameter logic [7:0]  PULL_ADDR = 8'h08
) (
  input logic          clk,
  input logic          rst_ok,
  input logic [AW-1:0] bus_addr,
  input logic          bus_wr,
  input logic [W-1:0]  bus_wdata,
  input logic          suspend,
  input logic [W-1:0]  sink_en,
  input logic [W-1:0]  pullup_en,
  input logic [W-1:0]  hiz,
  input logic [W-1:0]  data_q,
  input logic [W-1:0]  pend_q,
  input logic [W-1:0]  lvl,
  input logic [W-1:0]  lvl_prev
);
  // R1 R2 R3: at most one pad control per pin
  assert_exclusive_ctl_R1: assert property (@(posedge clk) disable iff (!rst_ok)
    ((sink_en & pullup_en) | (sink_en & hiz) | (pullup_en & hiz)) == '0);

  // R4: no sink drive in suspend
  assert_suspend_nosink_R4: assert property (@(posedge clk) disable iff (!rst_ok)
    suspend |-> (sink_en == '0));

  // R6: write to pull-up address sets float pattern next cycle
  assert_pull_write_R6: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_wr && bus_addr == PULL_ADDR[AW-1:0]) |=> (hiz == (data_q & $past(bus_wdata))));

  // R8 R9: a pending bit only appears where the synchronized level changed
  assert_pend_needs_edge_R8: assert property (@(posedge clk) disable iff (!rst_ok)
    1'b1 |=> ((pend_q & ~$past(pend_q) & ~($past(lvl) ^ $past(lvl_prev))) == '0));

  // R10: bits not cleared by a write stay set
  assert_pend_sticky_R10: assert property (@(posedge clk) disable iff (!rst_ok)
    !bus_wr |=> ((($past(pend_q)) & ~pend_q) == '0));
endmodule

bind gpio_pullup_port gpio_pullup_port_chk #(
  .W         (W),
  .AW        (AW),
  .PULL_ADDR (PULL_ADDR)
) u_chk (
  .clk       (clk),
  .rst_ok    (rst_ok),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_wdata (bus_wdata),
  .suspend   (suspend),
  .sink_en   (sink_en),
  .pullup_en (pullup_en),
  .hiz       (hiz),
  .data_q    (data_q),
  .pend_q    (pend_q),
  .lvl       (lvl),
  .lvl_prev  (lvl_prev)
);

// File: tb/gpio_pullup_port_tb.sv
module gpio_pullup_port_tb;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] A_DATA = 8'h00;
  localparam logic [7:0] A_PULL = 8'h08;
  localparam logic [7:0] A_IEN  = 8'h20;
  localparam logic [7:0] A_PEND = 8'h24;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic       bus_wr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;
  logic [7:0] pin_in;
  logic       suspend;
  logic [7:0] sink_en, pullup_en, hiz;
  logic       irq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gpio_pullup_port u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_in    (pin_in),
    .suspend   (suspend),
    .sink_en   (sink_en),
    .pullup_en (pullup_en),
    .hiz       (hiz),
    .irq       (irq)
  );

  task automatic check(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=0x%02h expected=0x%02h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0; bus_addr = 8'hFF;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    #1;
    d = bus_rdata;
    bus_addr = 8'hFF;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] r;
    check("R5", "pullup_en", pullup_en, 8'hFF);
    check("R5", "sink_en", sink_en, 8'h00);
    check("R5", "hiz", hiz, 8'h00);
    check("R5", "irq", {7'd0, irq}, 8'h00);
    bus_read(A_PEND, r); check("R5", "pending", r, 8'h00);
    bus_read(A_IEN, r);  check("R5", "enable mask", r, 8'h00);
    bus_read(A_DATA, r); check("R5", "pin level", r, 8'hFF);
  endtask

  task automatic t_drive();
    logic [7:0] r;
    bus_write(A_DATA, 8'hF0);
    bus_write(A_PULL, 8'hCC);
    check("R1", "sink_en", sink_en, 8'h0F);
    check("R1", "pullup_en low nibble", pullup_en & 8'h0F, 8'h00);
    check("R2", "pullup_en", pullup_en, 8'h30);
    check("R3", "hiz", hiz, 8'hC0);
    bus_read(A_PULL, r); check("R6", "pull-up readback", r, 8'h00);
    bus_write(A_PULL, 8'h00);
    check("R6", "hiz after pull clear", hiz, 8'h00);
  endtask

  task automatic t_suspend();
    suspend = 1'b1; #1;
    check("R4", "sink_en in suspend", sink_en, 8'h00);
    check("R4", "pullup_en in suspend", pullup_en, 8'hF0);
    suspend = 1'b0; #1;
    check("R4", "sink_en after suspend", sink_en, 8'h0F);
  endtask

  task automatic t_readback();
    logic [7:0] r;
    bus_write(A_DATA, 8'h00);
    pin_in = 8'hA5;
    @(negedge clk);
    bus_read(A_DATA, r); check("R7", "level after one edge", r, 8'hFF);
    @(negedge clk);
    bus_read(A_DATA, r); check("R7", "level after two edges", r, 8'hA5);
    pin_in = 8'hFF;
    bus_write(A_DATA, 8'hFF);
    settle();
    bus_write(A_PEND, 8'hFF);
    bus_read(A_DATA, r); check("R7", "level restored", r, 8'hFF);
  endtask

  task automatic t_fall_edge();
    logic [7:0] r;
    bus_write(A_PULL, 8'h00);
    bus_write(A_IEN, 8'hFF);
    bus_write(A_PEND, 8'hFF);
    pin_in = 8'hFE; settle();
    bus_read(A_PEND, r); check("R8", "falling edge pending", r, 8'h01);
    check("R11", "irq with enabled pending", {7'd0, irq}, 8'h01);
    pin_in = 8'hFF; settle();
    bus_read(A_PEND, r); check("R8", "rising edge ignored", r, 8'h01);
    bus_write(A_PEND, 8'h01);
    bus_read(A_PEND, r); check("R10", "cleared by one", r, 8'h00);
    check("R11", "irq after clear", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_rise_edge();
    logic [7:0] r;
    bus_write(A_PULL, 8'h02);
    pin_in = 8'hFD; settle();
    bus_read(A_PEND, r); check("R9", "falling edge ignored", r, 8'h00);
    pin_in = 8'hFF; settle();
    bus_read(A_PEND, r); check("R9", "rising edge pending", r, 8'h02);
    bus_write(A_PULL, 8'h00);
    pin_in = 8'hFE; settle();
    bus_read(A_PEND, r); check("R10", "sticky two bits", r, 8'h03);
    bus_write(A_PEND, 8'h01);
    bus_read(A_PEND, r); check("R10", "zero bits kept", r, 8'h02);
    pin_in = 8'hFF; settle();
  endtask

  task automatic t_mask();
    logic [7:0] r;
    bus_write(A_IEN, 8'h01);
    bus_read(A_IEN, r); check("R11", "enable readback", r, 8'h01);
    check("R11", "irq masked", {7'd0, irq}, 8'h00);
    bus_write(A_IEN, 8'h02);
    check("R11", "irq unmasked", {7'd0, irq}, 8'h01);
    bus_write(A_PEND, 8'hFF);
  endtask

  task automatic t_collision();
    logic [7:0] r;
    bus_write(A_PULL, 8'h00);
    pin_in = 8'hEF;          // bit4 falls
    @(negedge clk);
    @(negedge clk);          // event is live in this cycle
    bus_write(A_PEND, 8'h10);
    bus_read(A_PEND, r); check("R10", "set wins over clear", r, 8'h10);
    pin_in = 8'hFF; settle();
    bus_write(A_PEND, 8'hFF);
    bus_read(A_PEND, r); check("R10", "cleared afterwards", r, 8'h00);
  endtask

  initial begin
    rst_n = 1'b0; bus_addr = 8'hFF; bus_wr = 1'b0; bus_wdata = 8'h00;
    pin_in = 8'hFF; suspend = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_drive();
    t_suspend();
    t_readback();
    t_fall_edge();
    t_rise_edge();
    t_mask();
    t_collision();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog all actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule